// File: doc/BRIEF.md
# Second-Address Slave Status Flags

This block keeps two status flags for an I2C slave that answers, besides its main address, a second 7-bit address held in a register. It sees the bus only through decoded events: a start-condition pulse, a pulse for each received frame with its eight bits, set pulses from the transmit-empty and receive-full flags, and a pulse when the interrupt request flag is cleared. A mode bit selects master or slave operation. A format bit selects I2C format (0) or another serial format (1).

The second-address flag reports that the first frame after a start carried the second address. The continuous-transfer flag reports that a transmit-empty or receive-full event has occurred. In I2C slave mode it does so only while the second address is recognized. Software reads both flags through a status read strobe. It clears a flag only by reading it as 1 and then writing 0 to it. Bus and interrupt events also clear the flags in hardware.

Top module: `slv2_status_flags`

## Requirements
- R1: After a synchronous reset both `o_sec_hit` and `o_cont_xfer` are 0.
- R2: In I2C slave mode (`i_master`=0, `i_fmt_sel`=0), when the first frame after a start has bits [7:1] equal to `i_sec_addr`, `o_sec_hit` is 1 from the next cycle. Frame bit 0 (direction) is ignored.
- R3: `o_sec_hit` does not set in any of three cases: the address bits differ, the frame is not the first after a start, or `i_fmt_sel`=1.
- R4: A start pulse that comes without a frame pulse clears `o_sec_hit` in the next cycle.
- R5: While `i_master`=1, `o_sec_hit` is 0 from the next cycle, and frames do not set it.
- R6: A write with `i_wdata` bit 0 = 0, done after a read strobe that saw `o_sec_hit`=1, clears `o_sec_hit`. A write with bit 1 = 0, done after a read strobe that saw `o_cont_xfer`=1, clears `o_cont_xfer`.
- R7: A write of 0 with no earlier read of 1 leaves a flag unchanged. Any write, including a write of 1, uses up a pending read of 1.
- R8: A hardware clear of a flag cancels its pending read of 1. A later write of 0 then has no effect on the flag once it has set again.
- R9: In I2C slave mode, a transmit-empty or receive-full event sets `o_cont_xfer` only if `o_sec_hit` is 1.
- R10: In master mode or with `i_fmt_sel`=1, any transmit-empty or receive-full event sets `o_cont_xfer`.
- R11: An `i_irq_clr` pulse clears `o_cont_xfer` in the next cycle, even if a set event occurs in the same cycle.
- R12: A set event in the same cycle as a valid software clear leaves `o_cont_xfer` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_start | input | 1 | Start condition detected (one-cycle pulse) |
| i_frame_vld | input | 1 | Received frame valid (one-cycle pulse) |
| i_frame_data | input | 8 | Received frame: [7:1] address, [0] direction |
| i_tx_empty_set | input | 1 | Transmit-empty flag set event |
| i_rx_full_set | input | 1 | Receive-full flag set event |
| i_irq_clr | input | 1 | Interrupt request flag cleared to 0 |
| i_master | input | 1 | 1 = master mode, 0 = slave mode |
| i_fmt_sel | input | 1 | 0 = I2C format with second address, 1 = other format |
| i_sec_addr | input | 7 | Programmed second slave address |
| i_rd | input | 1 | Status register read strobe |
| i_wr | input | 1 | Status register write strobe |
| i_wdata | input | 2 | Write data: [0] second-address flag, [1] continuous-transfer flag |
| o_sec_hit | output | 1 | Second address recognized |
| o_cont_xfer | output | 1 | Continuous-transfer state |

## Verification
The assertions assume that a start pulse and a frame pulse never occur in the same cycle, and that all event inputs are single-cycle pulses. The start-clear property is written for start pulses that come without a frame. The bench drives each event in its own cycle on the falling edge. The one exception is the deliberate overlaps of the priority cases for interrupt clear and software clear, which involve only set and clear events of the continuous-transfer flag. The mode bits change only between transfers, and a start follows each such change. This way no first-frame window is left open across a mode change.

// File: rtl/slv2_pkg.sv
// Package slv2_pkg
// Shared widths and status-bit positions for the second-address flag block.
// Assumes: software writes the status register with the bit layout below.
package slv2_pkg;
    localparam int ADDR_W  = 7;
    localparam int FRAME_W = ADDR_W + 1;
    localparam int STAT_W  = 2;
    localparam int BIT_SEC  = 0;   // second-address flag position
    localparam int BIT_CONT = 1;   // continuous-transfer flag position
endpackage

// File: rtl/slv2_addr_match.sv
// Module slv2_addr_match
// Tracks whether the next received frame is the first after a start.
// Compares that frame's address bits with the second address.
// Assumes: start and frame pulses never occur in the same cycle.
module slv2_addr_match #(
    parameter int ADDR_W = slv2_pkg::ADDR_W,
    localparam int FRAME_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_start,
    input  logic              i_frame_vld,
    input  logic [FRAME_W-1:0] i_frame_data,
    input  logic [ADDR_W-1:0] i_sec_addr,
    input  logic              i_enable,
    output logic              o_hit
);
    logic first_pend;

    // Arm on start, disarm on any received frame.
    always_ff @(posedge clk) begin
        if (!rst_n)           first_pend <= 1'b0;
        else if (i_start)     first_pend <= 1'b1;
        else if (i_frame_vld) first_pend <= 1'b0;
    end

    // Match: first frame, address bits only, direction bit ignored.
    always_comb begin
        o_hit = i_enable && i_frame_vld && first_pend &&
                (i_frame_data[FRAME_W-1:1] == i_sec_addr);
    end
endmodule

// File: rtl/slv2_rc_flag.sv
// Module slv2_rc_flag
// One status flag that software clears by reading 1 and then writing 0.
// Holds a "read as 1" arm bit. Any write uses up the arm bit and any hardware clear drops it.
// SET_OVER_HWCLR chooses whether a hardware set beats a same-cycle hardware clear.
// A hardware set always beats a same-cycle software clear.
module slv2_rc_flag #(
    parameter bit SET_OVER_HWCLR = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic i_set,
    input  logic i_hw_clr,
    input  logic i_rd,
    input  logic i_wr,
    input  logic i_wbit,
    output logic o_q
);
    logic q, q_nx;
    logic armed, armed_nx;
    logic sw_clr;

    // Software clear is honoured only after a read that returned 1.
    always_comb sw_clr = i_wr && !i_wbit && armed;

    // Next flag value under the selected priority.
    generate
        if (SET_OVER_HWCLR) begin : g_set_first
            always_comb begin
                if (i_set)                   q_nx = 1'b1;
                else if (i_hw_clr || sw_clr) q_nx = 1'b0;
                else                         q_nx = q;
            end
        end else begin : g_clr_first
            always_comb begin
                if (i_hw_clr)    q_nx = 1'b0;
                else if (i_set)  q_nx = 1'b1;
                else if (sw_clr) q_nx = 1'b0;
                else             q_nx = q;
            end
        end
    endgenerate

    // Arm bit: hardware clear drops it, a write uses it up, a read of 1 sets it.
    always_comb begin
        if (i_hw_clr)       armed_nx = 1'b0;
        else if (i_wr)      armed_nx = 1'b0;
        else if (i_rd && q) armed_nx = 1'b1;
        else                armed_nx = armed;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= 1'b0;
            armed <= 1'b0;
        end else begin
            q     <= q_nx;
            armed <= armed_nx;
        end
    end

    always_comb o_q = q;
endmodule

// File: rtl/slv2_status_flags.sv
// Module slv2_status_flags
// Top level: second-address recognized flag and continuous-transfer flag.
// Assumes: event inputs are single-cycle pulses and the mode bits change only between transfers.
module slv2_status_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       i_start,
    input  logic       i_frame_vld,
    input  logic [7:0] i_frame_data,
    input  logic       i_tx_empty_set,
    input  logic       i_rx_full_set,
    input  logic       i_irq_clr,
    input  logic       i_master,
    input  logic       i_fmt_sel,
    input  logic [6:0] i_sec_addr,
    input  logic       i_rd,
    input  logic       i_wr,
    input  logic [1:0] i_wdata,
    output logic       o_sec_hit,
    output logic       o_cont_xfer
);
    import slv2_pkg::*;

    logic slave_i2c;
    logic addr_hit;
    logic cont_set;

    // Mode decode: the second address is live only as an I2C-format slave.
    always_comb slave_i2c = !i_master && !i_fmt_sel;

    slv2_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .i_start     (i_start),
        .i_frame_vld (i_frame_vld),
        .i_frame_data(i_frame_data),
        .i_sec_addr  (i_sec_addr),
        .i_enable    (slave_i2c),
        .o_hit       (addr_hit)
    );

    slv2_rc_flag #(.SET_OVER_HWCLR(1'b1)) u_sec_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_set   (addr_hit),
        .i_hw_clr(i_start || i_master),
        .i_rd    (i_rd),
        .i_wr    (i_wr),
        .i_wbit  (i_wdata[BIT_SEC]),
        .o_q     (o_sec_hit)
    );

    // Continuous-transfer set: gated by the recognized second address in I2C slave mode.
    always_comb cont_set = (i_tx_empty_set || i_rx_full_set) &&
                           (!slave_i2c || o_sec_hit);

    slv2_rc_flag #(.SET_OVER_HWCLR(1'b0)) u_cont_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_set   (cont_set),
        .i_hw_clr(i_irq_clr),
        .i_rd    (i_rd),
        .i_wr    (i_wr),
        .i_wbit  (i_wdata[BIT_CONT]),
        .o_q     (o_cont_xfer)
    );
endmodule

// File: rtl/slv2_status_sva.sv
// Module slv2_status_sva
// Checker for slv2_status_flags, attached by bind.
// Assumes: start and frame pulses never occur in the same cycle.
module slv2_status_sva (
    input logic clk,
    input logic rst_n,
    input logic i_start,
    input logic i_frame_vld,
    input logic i_tx_empty_set,
    input logic i_rx_full_set,
    input logic i_irq_clr,
    input logic i_master,
    input logic i_fmt_sel,
    input logic o_sec_hit,
    input logic o_cont_xfer
);
    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (!o_sec_hit && !o_cont_xfer)); // R1
    AST_HIT_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(o_sec_hit) |-> $past(i_frame_vld)); // R2
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (i_start && !i_frame_vld) |=> !o_sec_hit); // R4
    AST_MASTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        i_master |=> !o_sec_hit); // R5
    AST_CONT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!o_cont_xfer && !o_sec_hit && !i_master && !i_fmt_sel) |=> !o_cont_xfer); // R9
    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        i_irq_clr |=> !o_cont_xfer); // R11
    AST_CONT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (o_cont_xfer && !i_irq_clr && (i_tx_empty_set || i_rx_full_set)) |=> o_cont_xfer); // R12
endmodule

bind slv2_status_flags slv2_status_sva u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .i_start       (i_start),
    .i_frame_vld   (i_frame_vld),
    .i_tx_empty_set(i_tx_empty_set),
    .i_rx_full_set (i_rx_full_set),
    .i_irq_clr     (i_irq_clr),
    .i_master      (i_master),
    .i_fmt_sel     (i_fmt_sel),
    .o_sec_hit     (o_sec_hit),
    .o_cont_xfer   (o_cont_xfer)
);

// File: tb/test_slv2_status_flags.sv
`timescale 1ns/1ps
module test_slv2_status_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       i_start = 1'b0, i_frame_vld = 1'b0;
    logic [7:0] i_frame_data = 8'h00;
    logic       i_tx_empty_set = 1'b0, i_rx_full_set = 1'b0, i_irq_clr = 1'b0;
    logic       i_master = 1'b0, i_fmt_sel = 1'b0;
    logic [6:0] i_sec_addr = 7'h35;
    logic       i_rd = 1'b0, i_wr = 1'b0;
    logic [1:0] i_wdata = 2'b00;
    logic       o_sec_hit, o_cont_xfer;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    slv2_status_flags i_slv2_status_flags (.*);

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Every stimulus is set at a falling edge and released one cycle later.
    task automatic tick();
        @(negedge clk);
        {i_start, i_frame_vld, i_tx_empty_set, i_rx_full_set, i_irq_clr, i_rd, i_wr} = '0;
    endtask
    task automatic start_ev(); i_start = 1'b1; tick(); endtask
    task automatic frame_ev(input logic [6:0] a, input logic rw);
        i_frame_data = {a, rw}; i_frame_vld = 1'b1; tick();
    endtask
    task automatic rd_ev(); i_rd = 1'b1; tick(); endtask
    task automatic wr_ev(input logic [1:0] d); i_wdata = d; i_wr = 1'b1; tick(); endtask
    task automatic get_hit(); start_ev(); frame_ev(7'h35, 1'b0); endtask

    task automatic t_reset();
        chk("R1 sec", o_sec_hit, 1'b0);
        chk("R1 cont", o_cont_xfer, 1'b0);
    endtask

    task automatic t_match();
        start_ev(); frame_ev(7'h35, 1'b1);
        chk("R2 match rw=1", o_sec_hit, 1'b1);
        start_ev();
        chk("R4 start clears", o_sec_hit, 1'b0);
        frame_ev(7'h35, 1'b0);
        chk("R2 match rw=0", o_sec_hit, 1'b1);
        start_ev();
    endtask

    task automatic t_nomatch();
        start_ev(); frame_ev(7'h36, 1'b0);
        chk("R3 mismatch", o_sec_hit, 1'b0);
        frame_ev(7'h35, 1'b0);
        chk("R3 second frame", o_sec_hit, 1'b0);
        i_fmt_sel = 1'b1; start_ev(); frame_ev(7'h35, 1'b0);
        chk("R3 fmt_sel=1", o_sec_hit, 1'b0);
        i_fmt_sel = 1'b0; start_ev();
    endtask

    task automatic t_master();
        get_hit();
        i_master = 1'b1; tick();
        chk("R5 master clears", o_sec_hit, 1'b0);
        start_ev(); frame_ev(7'h35, 1'b0);
        chk("R5 no set in master", o_sec_hit, 1'b0);
        i_master = 1'b0; start_ev();
    endtask

    task automatic t_swclr();
        get_hit();
        wr_ev(2'b00);
        chk("R7 blind write0", o_sec_hit, 1'b1);
        rd_ev(); wr_ev(2'b01);
        chk("R7 write1 no effect", o_sec_hit, 1'b1);
        wr_ev(2'b00);
        chk("R7 arm consumed", o_sec_hit, 1'b1);
        rd_ev(); wr_ev(2'b00);
        chk("R6 read then write0", o_sec_hit, 1'b0);
    endtask

    task automatic t_arm_drop();
        get_hit();
        rd_ev(); start_ev();
        frame_ev(7'h35, 1'b0);
        wr_ev(2'b00);
        chk("R8 hw clear drops arm", o_sec_hit, 1'b1);
        start_ev();
    endtask

    task automatic t_cont_gate();
        i_tx_empty_set = 1'b1; tick();
        chk("R9 gated off", o_cont_xfer, 1'b0);
        get_hit();
        i_rx_full_set = 1'b1; tick();
        chk("R9 gated on", o_cont_xfer, 1'b1);
        i_irq_clr = 1'b1; tick();
        chk("R11 irq clears", o_cont_xfer, 1'b0);
        i_tx_empty_set = 1'b1; tick();
        chk("R9 set again", o_cont_xfer, 1'b1);
        i_irq_clr = 1'b1; i_tx_empty_set = 1'b1; tick();
        chk("R11 clear beats set", o_cont_xfer, 1'b0);
        start_ev();
    endtask

    task automatic t_cont_other();
        i_fmt_sel = 1'b1; i_tx_empty_set = 1'b1; tick();
        chk("R10 fmt_sel=1 sets", o_cont_xfer, 1'b1);
        rd_ev(); wr_ev(2'b00);
        chk("R6 cont sw clear", o_cont_xfer, 1'b0);
        i_fmt_sel = 1'b0; i_master = 1'b1; i_rx_full_set = 1'b1; tick();
        chk("R10 master sets", o_cont_xfer, 1'b1);
        rd_ev();
        i_wdata = 2'b00; i_wr = 1'b1; i_tx_empty_set = 1'b1; tick();
        chk("R12 set beats sw clear", o_cont_xfer, 1'b1);
        wr_ev(2'b00);
        chk("R7 cont blind write0", o_cont_xfer, 1'b1);
        i_irq_clr = 1'b1; tick();
        i_master = 1'b0; start_ev();
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset(); t_match(); t_nomatch(); t_master();
                t_swclr(); t_arm_drop(); t_cont_gate(); t_cont_other();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule